// File: doc/BRIEF.md
# Accumulator Tape Instruction Sequencer

This block is a small single-accumulator machine. It fetches 16-bit instruction words in order from an internal instruction store (the tape) and executes each against an internal data store of 64 words of 22 bits. Loads and stores move words between the accumulator and the data store. Add, subtract and multiply are handed to an external arithmetic unit through a start/done handshake, and the result replaces the accumulator. There are no branches.

A host first fills the tape and the data store through two write ports. It then sets the tape length and pulses `start`. The machine runs until it executes a halt word or its program counter reaches the end of the tape. It then raises `halted` and stays put until the next `start`. A one-cycle trace strobe reports every fetched word together with the position it came from.

The arithmetic link is a plain request/response pair. `fpu_start` pulses for one cycle. The operands and the operation code are held steady until the unit answers with a one-cycle `fpu_done`. The unit has no way to apply back-pressure other than delaying `fpu_done`. No other interface carries a stream, so the remaining pins are plain control and status.

Top module: `tape_sequencer`

## Requirements
- R1: After reset the accumulator and program counter read zero, and `halted`, `trace_valid` and `fpu_start` are low.
- R2: A `start` pulse clears the program counter, the accumulator and `halted` on the next clock edge. The machine then fetches from tape word 0. `start` takes precedence over every other activity, including a run already in progress.
- R3: In an instruction word, bits 15:8 hold the opcode and bits 5:0 hold the data address. Bits 7:6 have no effect on which word is addressed.
- R4: Opcode 0x01 copies the addressed data word into the accumulator. Opcode 0x02 writes the accumulator into the addressed data word. An internal store takes priority over an external data write in the same cycle.
- R5: Opcodes 0x03, 0x04 and 0x05 issue one request with `fpu_op` = 0 (add), 1 (subtract) or 2 (multiply), `fpu_a` = accumulator and `fpu_b` = addressed data word. `fpu_start` is high for exactly one cycle. The machine waits, with the accumulator unchanged, until `fpu_done`, and then loads `fpu_result` into the accumulator.
- R6: Opcode 0xFF sets `halted`. The program counter is then left pointing one past the halt word.
- R7: When the program counter equals the tape length (capped at the tape depth), the machine sets `halted` and executes nothing more. The program counter then reads the capped length, and a length of 0 halts with no fetch at all.
- R8: Any other opcode only advances the program counter. The accumulator and the data store are untouched.
- R9: While halted and without `start`, there is no fetch, trace or arithmetic request, and the program counter and accumulator hold still, even if the tape is rewritten.
- R10: Each fetched word produces a one-cycle `trace_valid` carrying its tape position on `trace_pc` and the whole word on `trace_instr`. In that cycle `pc` already equals `trace_pc` + 1 and the accumulator still holds the result of all earlier words.
- R11: Holding the tape length in place during a run and supplying a new one with a fresh `start` restarts execution from word 0 under the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) execution from tape word 0 |
| tape_len | input | 7 | Number of tape words to run |
| tape_we | input | 1 | Tape write enable |
| tape_waddr | input | 6 | Tape write position |
| tape_wdata | input | 16 | Tape word: opcode in 15:8, address byte in 7:0 |
| dmem_we | input | 1 | External data-store write enable |
| dmem_waddr | input | 6 | External data-store write address |
| dmem_wdata | input | 22 | External data-store write word |
| fpu_start | output | 1 | One-cycle arithmetic request |
| fpu_op | output | 2 | 0 add, 1 subtract, 2 multiply |
| fpu_a | output | 22 | First operand (accumulator) |
| fpu_b | output | 22 | Second operand (data word) |
| fpu_done | input | 1 | One-cycle completion from the arithmetic unit |
| fpu_result | input | 22 | Arithmetic result, valid with `fpu_done` |
| acc | output | 22 | Accumulator |
| pc | output | 7 | Program counter |
| halted | output | 1 | Machine has stopped |
| trace_valid | output | 1 | One-cycle strobe per fetched word |
| trace_pc | output | 7 | Tape position of the traced word |
| trace_instr | output | 16 | Traced instruction word |

## Verification
The checker watches several properties on every clock edge. It requires that the arithmetic request lasts one cycle and that the accumulator stays frozen while a request is outstanding. It also requires that a halted machine stays halted and silent with `pc` and the accumulator stable, that `start` clears state, and that the trace strobe is a single cycle with `pc` one ahead of it. Other behaviour only shows up over a whole program, and the bench's scenarios cover it. This includes the arithmetic and data-movement results, the ignored address bits, the stores checked back through later loads, and unknown opcodes that leave data intact. It also covers where `pc` rests after a halt word, after the end of the tape, after a zero length and after a length above the tape depth, and a restart partway through a run.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OPC_W = 8;
  localparam int ABYTE_W = 8;
  localparam int IW_W = OPC_W + ABYTE_W;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 8'h01;
  localparam logic [OPC_W-1:0] OPC_STORE = 8'h02;
  localparam logic [OPC_W-1:0] OPC_ADD   = 8'h03;
  localparam logic [OPC_W-1:0] OPC_SUB   = 8'h04;
  localparam logic [OPC_W-1:0] OPC_MUL   = 8'h05;
  localparam logic [OPC_W-1:0] OPC_HALT  = 8'hFF;

  typedef enum logic [1:0] {
    AOP_ADD = 2'd0,
    AOP_SUB = 2'd1,
    AOP_MUL = 2'd2
  } aop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_WAIT
  } seq_st_e;

endpackage

// File: rtl/seq_ram.sv
// Simple storage array: one synchronous write port, one asynchronous read port.
module seq_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 22,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/seq_decode.sv
// Opcode classification; unknown codes fall through with every class low.
module seq_decode import seq_pkg::*; #(
  parameter int DA_W = 6
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [DA_W-1:0]  abits,
  output logic             is_load,
  output logic             is_store,
  output logic             is_arith,
  output logic             is_halt,
  output aop_e             aop,
  output logic [DA_W-1:0]  daddr
);

  always_comb begin
    is_load  = 1'b0;
    is_store = 1'b0;
    is_arith = 1'b0;
    is_halt  = 1'b0;
    aop      = AOP_ADD;
    daddr    = abits;
    case (opc)
      OPC_LOAD:  is_load  = 1'b1;
      OPC_STORE: is_store = 1'b1;
      OPC_ADD:   begin is_arith = 1'b1; aop = AOP_ADD; end
      OPC_SUB:   begin is_arith = 1'b1; aop = AOP_SUB; end
      OPC_MUL:   begin is_arith = 1'b1; aop = AOP_MUL; end
      OPC_HALT:  is_halt  = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/tape_sequencer.sv
module tape_sequencer import seq_pkg::*; #(
  parameter int TAPE_DEPTH = 64,
  parameter int DATA_DEPTH = 64,
  parameter int WORD_W = 22,
  localparam int TA_W = $clog2(TAPE_DEPTH),
  localparam int PC_W = TA_W + 1,
  localparam int DA_W = $clog2(DATA_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PC_W-1:0]   tape_len,
  input  logic              tape_we,
  input  logic [TA_W-1:0]   tape_waddr,
  input  logic [IW_W-1:0]   tape_wdata,
  input  logic              dmem_we,
  input  logic [DA_W-1:0]   dmem_waddr,
  input  logic [WORD_W-1:0] dmem_wdata,
  output logic              fpu_start,
  output logic [1:0]        fpu_op,
  output logic [WORD_W-1:0] fpu_a,
  output logic [WORD_W-1:0] fpu_b,
  input  logic              fpu_done,
  input  logic [WORD_W-1:0] fpu_result,
  output logic [WORD_W-1:0] acc,
  output logic [PC_W-1:0]   pc,
  output logic              halted,
  output logic              trace_valid,
  output logic [PC_W-1:0]   trace_pc,
  output logic [IW_W-1:0]   trace_instr
);

  localparam logic [PC_W-1:0] DEPTH_PC = PC_W'(TAPE_DEPTH);

  seq_st_e           state;
  logic [OPC_W-1:0]  ir_opc;
  logic [DA_W-1:0]   ir_addr;
  aop_e              fpu_op_q;
  logic [IW_W-1:0]   tape_rdata;
  logic [WORD_W-1:0] dm_rdata;
  logic [PC_W-1:0]   eff_len;
  logic              at_end;
  logic              waiting;

  logic              dec_load, dec_store, dec_arith, dec_halt;
  aop_e              dec_aop;
  logic [DA_W-1:0]   dec_addr;

  logic              int_store;
  logic              dm_we;
  logic [DA_W-1:0]   dm_waddr;
  logic [WORD_W-1:0] dm_wdata;

  // Tape length above the store depth is capped to the depth.
  assign eff_len = (tape_len > DEPTH_PC) ? DEPTH_PC : tape_len;
  assign at_end  = (pc >= eff_len);
  assign waiting = (state == ST_WAIT);

  seq_ram #(.DEPTH(TAPE_DEPTH), .WIDTH(IW_W)) u_tape (
    .clk   (clk),
    .we    (tape_we),
    .waddr (tape_waddr),
    .wdata (tape_wdata),
    .raddr (pc[TA_W-1:0]),
    .rdata (tape_rdata)
  );

  seq_decode #(.DA_W(DA_W)) u_dec (
    .opc      (ir_opc),
    .abits    (ir_addr),
    .is_load  (dec_load),
    .is_store (dec_store),
    .is_arith (dec_arith),
    .is_halt  (dec_halt),
    .aop      (dec_aop),
    .daddr    (dec_addr)
  );

  // Internal store wins over an external write in the same cycle.
  assign int_store = (state == ST_EXEC) && dec_store && !start;
  assign dm_we     = int_store || dmem_we;
  assign dm_waddr  = int_store ? dec_addr : dmem_waddr;
  assign dm_wdata  = int_store ? acc : dmem_wdata;

  seq_ram #(.DEPTH(DATA_DEPTH), .WIDTH(WORD_W)) u_data (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (dec_addr),
    .rdata (dm_rdata)
  );

  assign fpu_a  = acc;
  assign fpu_op = fpu_op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pc          <= '0;
      acc         <= '0;
      halted      <= 1'b0;
      ir_opc      <= '0;
      ir_addr     <= '0;
      fpu_start   <= 1'b0;
      fpu_op_q    <= AOP_ADD;
      fpu_b       <= '0;
      trace_valid <= 1'b0;
      trace_pc    <= '0;
      trace_instr <= '0;
    end else begin
      trace_valid <= 1'b0;
      fpu_start   <= 1'b0;
      if (start) begin
        state  <= ST_FETCH;
        pc     <= '0;
        acc    <= '0;
        halted <= 1'b0;
      end else begin
        case (state)
          ST_FETCH: begin
            if (at_end) begin
              halted <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              ir_opc      <= tape_rdata[IW_W-1 -: OPC_W];
              ir_addr     <= tape_rdata[DA_W-1:0];
              trace_valid <= 1'b1;
              trace_pc    <= pc;
              trace_instr <= tape_rdata;
              pc          <= pc + PC_W'(1);
              state       <= ST_EXEC;
            end
          end
          ST_EXEC: begin
            state <= ST_FETCH;
            if (dec_load) acc <= dm_rdata;
            if (dec_arith) begin
              fpu_start <= 1'b1;
              fpu_op_q  <= dec_aop;
              fpu_b     <= dm_rdata;
              state     <= ST_WAIT;
            end
            if (dec_halt) begin
              halted <= 1'b1;
              state  <= ST_IDLE;
            end
          end
          ST_WAIT: begin
            if (fpu_done) begin
              acc   <= fpu_result;
              state <= ST_FETCH;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tape_sequencer_chk.sv
module tape_sequencer_chk #(
  parameter int PC_W = 7,
  parameter int WORD_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              halted,
  input logic              fpu_start,
  input logic              fpu_done,
  input logic              trace_valid,
  input logic              waiting,
  input logic [PC_W-1:0]   pc,
  input logic [PC_W-1:0]   trace_pc,
  input logic [WORD_W-1:0] acc
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pc == '0 && acc == '0 && !halted)); // R2

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_start |=> !fpu_start); // R5

  AST_ACC_FROZEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !fpu_done && !start) |=> $stable(acc)); // R5

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> (halted && $stable(pc) && $stable(acc))); // R9

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!trace_valid && !fpu_start)); // R9

  AST_TRACE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trace_valid |=> !trace_valid); // R10

  AST_TRACE_PC_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    trace_valid |-> (pc == PC_W'(trace_pc + PC_W'(1)))); // R10

endmodule

bind tape_sequencer tape_sequencer_chk #(.PC_W(PC_W), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .halted      (halted),
  .fpu_start   (fpu_start),
  .fpu_done    (fpu_done),
  .trace_valid (trace_valid),
  .waiting     (waiting),
  .pc          (pc),
  .trace_pc    (trace_pc),
  .acc         (acc)
);

// File: tb/sim_tape_sequencer.sv
`timescale 1ns/1ps
module sim_tape_sequencer;

  localparam int TD = 64;
  localparam int DD = 64;
  localparam int W = 22;
  localparam int TAW = 6;
  localparam int PCW = 7;
  localparam int DAW = 6;
  localparam longint MASK = (64'd1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PCW-1:0] tape_len = '0;
  logic tape_we = 1'b0;
  logic [TAW-1:0] tape_waddr = '0;
  logic [15:0] tape_wdata = '0;
  logic dmem_we = 1'b0;
  logic [DAW-1:0] dmem_waddr = '0;
  logic [W-1:0] dmem_wdata = '0;
  logic fpu_start;
  logic [1:0] fpu_op;
  logic [W-1:0] fpu_a, fpu_b;
  logic fpu_done = 1'b0;
  logic [W-1:0] fpu_result = '0;
  logic [W-1:0] acc;
  logic [PCW-1:0] pc;
  logic halted;
  logic trace_valid;
  logic [PCW-1:0] trace_pc;
  logic [15:0] trace_instr;

  tape_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tape_len(tape_len),
    .tape_we(tape_we), .tape_waddr(tape_waddr), .tape_wdata(tape_wdata),
    .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
    .fpu_start(fpu_start), .fpu_op(fpu_op), .fpu_a(fpu_a), .fpu_b(fpu_b),
    .fpu_done(fpu_done), .fpu_result(fpu_result),
    .acc(acc), .pc(pc), .halted(halted),
    .trace_valid(trace_valid), .trace_pc(trace_pc), .trace_instr(trace_instr)
  );

  always #4 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int fpu_lat = 1;
  int t_op [TD];
  int t_ab [TD];
  longint d_m [DD];
  int q_pc [$];
  int q_op [$];
  longint q_acc [$];
  int q_fop [$];
  longint q_fa [$];
  longint q_fb [$];
  int exp_pc;
  longint exp_acc;

  function automatic longint fmodel(int op, longint a, longint b);
    case (op)
      0: return (a + b) & MASK;
      1: return (a - b) & MASK;
      default: return (a * b) & MASK;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // Arithmetic unit stand-in: answers after fpu_lat cycles.
  initial begin : fpu_stub
    int cnt = 0;
    int op_c = 0;
    longint a_c = 0;
    longint b_c = 0;
    forever begin
      @(negedge clk);
      fpu_done = 1'b0;
      if (fpu_start) begin
        op_c = fpu_op; a_c = fpu_a; b_c = fpu_b; cnt = fpu_lat;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          fpu_done = 1'b1;
          fpu_result = W'(fmodel(op_c, a_c, b_c));
        end
      end
    end
  end

  task automatic put_tape(input int i, input int op, input int ab);
    @(negedge clk);
    tape_we = 1'b1; tape_waddr = TAW'(i); tape_wdata = {8'(op), 8'(ab)};
    t_op[i] = op; t_ab[i] = ab;
    @(negedge clk);
    tape_we = 1'b0;
  endtask

  task automatic put_data(input int i, input longint v);
    @(negedge clk);
    dmem_we = 1'b1; dmem_waddr = DAW'(i); dmem_wdata = W'(v);
    d_m[i] = v & MASK;
    @(negedge clk);
    dmem_we = 1'b0;
  endtask

  // Instruction-level reference: R3..R8, R10.
  task automatic model_run(input int len);
    int p = 0;
    longint a = 0;
    int eff = (len > TD) ? TD : len;
    q_pc.delete(); q_op.delete(); q_acc.delete();
    q_fop.delete(); q_fa.delete(); q_fb.delete();
    while (p < eff) begin
      int op = t_op[p];
      int ad = t_ab[p] & 63;
      q_pc.push_back(p); q_op.push_back(op); q_acc.push_back(a);
      p++;
      if (op == 255) break;
      case (op)
        1: a = d_m[ad];
        2: d_m[ad] = a;
        3, 4, 5: begin
          q_fop.push_back(op - 3); q_fa.push_back(a); q_fb.push_back(d_m[ad]);
          a = fmodel(op - 3, a, d_m[ad]);
        end
        default: ;
      endcase
    end
    exp_pc = p;
    exp_acc = a;
  endtask

  task automatic run_check(input int len, input string tag);
    model_run(len);
    @(negedge clk); tape_len = PCW'(len); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({"R2 pc cleared ", tag}, pc, 0);
    chk({"R2 acc cleared ", tag}, acc, 0);
    chk({"R2 halted cleared ", tag}, halted, 0);
    for (int c = 0; c < 4000 && !halted; c++) begin
      if (trace_valid) begin
        if (q_pc.size() == 0) begin
          chk({"R10 unexpected trace ", tag}, trace_pc, -1);
        end else begin
          chk({"R10 trace_pc ", tag}, trace_pc, q_pc.pop_front());
          chk({"R10 trace opcode ", tag}, trace_instr[15:8], q_op.pop_front());
          chk({"R10 acc at trace ", tag}, acc, q_acc.pop_front());
        end
      end
      if (fpu_start) begin
        if (q_fop.size() == 0) begin
          chk({"R5 unexpected request ", tag}, fpu_op, -1);
        end else begin
          chk({"R5 fpu_op ", tag}, fpu_op, q_fop.pop_front());
          chk({"R5 fpu_a ", tag}, fpu_a, q_fa.pop_front());
          chk({"R5 fpu_b ", tag}, fpu_b, q_fb.pop_front());
        end
      end
      @(negedge clk);
    end
    chk({"R6/R7 halted ", tag}, halted, 1);
    chk({"R6/R7 final pc ", tag}, pc, exp_pc);
    chk({"R4/R5 final acc ", tag}, acc, exp_acc);
    chk({"R10 missing traces ", tag}, q_pc.size(), 0);
    chk({"R5 missing requests ", tag}, q_fop.size(), 0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin : main
    longint hold_acc;
    int hold_pc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 acc", acc, 0);
    chk("R1 pc", pc, 0);
    chk("R1 halted", halted, 0);
    chk("R1 trace_valid", trace_valid, 0);
    chk("R1 fpu_start", fpu_start, 0);

    // Scenario A: (3*4)+(2*5), address bytes with bits 7:6 set (R3, R4, R5, R6)
    fpu_lat = 3;
    put_data(0, 3); put_data(1, 4); put_data(2, 2); put_data(3, 5); put_data(4, 0);
    put_tape(0, 8'h01, 8'hC0);
    put_tape(1, 8'h05, 8'h41);
    put_tape(2, 8'h02, 8'h84);
    put_tape(3, 8'h01, 8'h02);
    put_tape(4, 8'h05, 8'hC3);
    put_tape(5, 8'h03, 8'h04);
    put_tape(6, 8'hFF, 8'h00);
    put_tape(7, 8'h01, 8'h00);
    run_check(8, "A");
    chk("R6 product sum", acc, 22);
    chk("R6 pc past halt", pc, 7);

    // Scenario B: subtract, unknown opcodes, run off the tape end (R5, R7, R8)
    fpu_lat = 1;
    put_data(5, 100); put_data(6, 37); put_data(7, 0); put_data(8, 85);
    put_data(10, 1000);
    put_tape(0, 8'h01, 8'h05);
    put_tape(1, 8'h00, 8'h09);
    put_tape(2, 8'h04, 8'h06);
    put_tape(3, 8'h07, 8'h08);
    put_tape(4, 8'hFE, 8'h0A);
    put_tape(5, 8'h02, 8'h07);
    put_tape(6, 8'h01, 8'h0A);
    put_tape(7, 8'h03, 8'h07);
    run_check(8, "B");
    chk("R8 unknown opcodes leave data", acc, 1063);
    chk("R7 pc at tape end", pc, 8);

    // R9: halted machine ignores the tape and a rewrite of it
    hold_acc = acc;
    hold_pc = pc;
    put_tape(0, 8'h01, 8'h00);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R9 halted held", halted, 1);
      chk("R9 pc held", pc, hold_pc);
      chk("R9 acc held", acc, hold_acc);
      chk("R9 no trace", trace_valid, 0);
      chk("R9 no request", fpu_start, 0);
    end

    // R7: zero length halts with no fetch
    run_check(0, "len0");
    chk("R7 zero length pc", pc, 0);

    // R11: restart partway through a run of loads
    for (int i = 0; i < 10; i++) put_data(20 + i, 7 * i + 11);
    for (int i = 0; i < 10; i++) put_tape(i, 8'h01, 20 + i);
    @(negedge clk); tape_len = PCW'(10); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    run_check(4, "R11 restart");
    chk("R11 restart acc", acc, 7 * 3 + 11);

    // R7: length above depth is capped; multiply across the whole tape
    fpu_lat = 2;
    for (int i = 0; i < TD; i++) put_tape(i, 8'h00, 0);
    put_tape(0, 8'h01, 8'h05);
    put_tape(TD - 1, 8'h03, 8'h06);
    run_check(100, "cap");
    chk("R7 capped pc", pc, TD);
    chk("R7 capped acc", acc, 137);

    summary();
    $finish;
  end

endmodule